// File: doc/BRIEF.md
# Calibrated DAC Code Correction Unit

This unit takes an ideal 12-bit offset-binary converter count, which is 2048 at zero volts and spans 4096 codes across the 20 V range. It returns the count that a particular output channel needs once that channel's gain and offset errors are trimmed out. Each channel has two signed 8-bit coefficients, both in quarter-LSB units. The gain coefficient scales the distance from mid-scale by a factor of (1 + G/16384). The offset coefficient shifts the result by O/4 counts.

A sample enters with a valid strobe together with its two coefficients. Two clock edges later the unit presents the corrected count, rounded to the nearest integer and limited to the code range. It also presents the same count placed in the upper twelve bits of a 16-bit word, and a flag that shows when clamping was needed. A new sample can be accepted on every cycle.

Top module: `dac_cal_corrector`

## Requirements
- R1: While reset is held and on the first cycle after it, outValid, outCount, outWord and outSat are all zero.
- R2: Each cycle with inValid high yields exactly one cycle with outValid high, two rising edges later. Back-to-back inputs produce back-to-back results in the same order.
- R3: The exact value is V = (inIdeal − 2048) × (1 + inGain/16384) + 2048 + inOffset/4. When it stays in range, outCount is V rounded to the nearest integer.
- R4: inGain and inOffset are read as two's-complement 8-bit numbers (−128 to 127). Code 0x80 is therefore −128 and code 0x7F is +127.
- R5: A value exactly halfway between two integers rounds away from zero. For example, 2048.5 becomes 2049 and −0.5 becomes −1.
- R6: If the rounded value is below 0, outCount is 0 and outSat is 1.
- R7: If the rounded value is above 4095, outCount is 4095 and outSat is 1.
- R8: outWord is outCount in bits 15:4, with bits 3:0 at zero. For example, 1544 gives 16'h6080.
- R9: In cycles where outValid is low, outCount, outWord and outSat keep their last values.
- R10: outSat is 0 whenever the rounded value lies within 0..4095.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks a sample to correct |
| inIdeal | input | 12 | Ideal offset-binary count |
| inGain | input | 8 | Signed gain coefficient, quarter-LSB units |
| inOffset | input | 8 | Signed offset coefficient, quarter-LSB units |
| outValid | output | 1 | Result present this cycle |
| outCount | output | 12 | Corrected, rounded, clamped count |
| outWord | output | 16 | Corrected count, left-justified |
| outSat | output | 1 | Result was clamped |

## Verification
Rounding and clamping can decide the same sample. A value of 4095.5 is only pushed out of range by the round-away step. Likewise, −0.5 saturates while −0.25 does not. Directed samples sit exactly on these ties at both ends of the code range, and each is judged against a bench model for both the count and the flag. Random samples with random gaps between them then mix clamped and in-range results in adjacent cycles, so a sample in stage two can be checked for cross-talk from the sample behind it.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  // load strobes handed from control to datapath
  typedef struct packed {
    logic ldMul;   // capture product and offset term
    logic ldOut;   // capture rounded, clamped result
  } strobes_t;
endpackage

// File: rtl/dcc_ctrl.sv
module dcc_ctrl (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output dcc_pkg::strobes_t stb,
  output logic              outValid
);
  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    stb.ldMul = inValid;
    stb.ldOut = stage1Valid;
  end

  assign outValid = stage2Valid;
endmodule

// File: rtl/dcc_datapath.sv
module dcc_datapath #(
  parameter int CODE_W = 12,
  parameter int COEF_W = 8,
  parameter int FRAC_W = 14,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dcc_pkg::strobes_t        stb,
  input  logic [CODE_W-1:0]        ideal,
  input  logic signed [COEF_W-1:0] gainCoef,
  input  logic signed [COEF_W-1:0] offCoef,
  output logic [CODE_W-1:0]        count,
  output logic [WORD_W-1:0]        word,
  output logic                     sat
);
  localparam int DIFF_W = CODE_W + 1;
  localparam int GAIN_W = FRAC_W + 2;
  localparam int PROD_W = DIFF_W + GAIN_W;
  localparam int ACC_W  = PROD_W + 1;
  localparam int MID    = 1 << (CODE_W - 1);
  localparam int MAXC   = (1 << CODE_W) - 1;
  localparam int ONE    = 1 << FRAC_W;
  localparam int QSHIFT = FRAC_W - 2;   // quarter-LSB to fixed point
  localparam logic signed [ACC_W-1:0] MID_SC = ACC_W'(MID) << FRAC_W;
  localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(ONE >> 1);
  localparam logic signed [ACC_W-1:0] MAX_SC = ACC_W'(MAXC);

  // stage 1: centred code times gain factor, offset in fixed point
  logic signed [DIFF_W-1:0] diffS;
  logic signed [GAIN_W-1:0] gainS;
  logic signed [PROD_W-1:0] prodD, prodQ;
  logic signed [ACC_W-1:0]  offD, offQ;

  always_comb begin
    diffS = $signed({1'b0, ideal}) - $signed(DIFF_W'(MID));
    gainS = $signed(GAIN_W'(ONE)) + GAIN_W'(gainCoef);
    prodD = PROD_W'(diffS) * PROD_W'(gainS);
    offD  = ACC_W'(offCoef) <<< QSHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prodQ <= '0;
      offQ  <= '0;
    end else if (stb.ldMul) begin
      prodQ <= prodD;
      offQ  <= offD;
    end
  end

  // stage 2: sum, round half away from zero, clamp
  logic signed [ACC_W-1:0] acc, mag, rmag, rounded;
  logic [CODE_W-1:0]       countD;
  logic                    satD;

  always_comb begin
    acc     = ACC_W'(prodQ) + offQ + MID_SC;
    mag     = (acc < 0) ? -acc : acc;
    rmag    = (mag + HALF) >>> FRAC_W;
    rounded = (acc < 0) ? -rmag : rmag;
    if (rounded < 0) begin
      countD = '0;
      satD   = 1'b1;
    end else if (rounded > MAX_SC) begin
      countD = CODE_W'(MAXC);
      satD   = 1'b1;
    end else begin
      countD = rounded[CODE_W-1:0];
      satD   = 1'b0;
    end
  end

  logic [WORD_W-1:0] wordD;
  generate
    if (WORD_W > CODE_W) begin : g_pad
      assign wordD = {countD, {(WORD_W-CODE_W){1'b0}}};
    end else begin : g_nopad
      assign wordD = countD[CODE_W-1 -: WORD_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      word  <= '0;
      sat   <= 1'b0;
    end else if (stb.ldOut) begin
      count <= countD;
      word  <= wordD;
      sat   <= satD;
    end
  end
endmodule

// File: rtl/dac_cal_corrector.sv
module dac_cal_corrector #(
  parameter int CODE_W = 12,
  parameter int COEF_W = 8,
  parameter int FRAC_W = 14,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic [CODE_W-1:0]        inIdeal,
  input  logic signed [COEF_W-1:0] inGain,
  input  logic signed [COEF_W-1:0] inOffset,
  output logic                     outValid,
  output logic [CODE_W-1:0]        outCount,
  output logic [WORD_W-1:0]        outWord,
  output logic                     outSat
);
  dcc_pkg::strobes_t stb;

  dcc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .stb(stb), .outValid(outValid)
  );

  dcc_datapath #(.CODE_W(CODE_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .ideal(inIdeal), .gainCoef(inGain),
    .offCoef(inOffset), .count(outCount), .word(outWord), .sat(outSat)
  );
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int CODE_W = 12,
  parameter int COEF_W = 8,
  parameter int WORD_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     inValid,
  input logic [CODE_W-1:0]        inIdeal,
  input logic signed [COEF_W-1:0] inOffset,
  input logic                     outValid,
  input logic [CODE_W-1:0]        outCount,
  input logic [WORD_W-1:0]        outWord,
  input logic                     outSat
);
  localparam int MID  = 1 << (CODE_W - 1);
  localparam int MAXC = (1 << CODE_W) - 1;

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    outValid == $past(inValid, 2));

  p_midscale_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && inIdeal == CODE_W'(MID) && inOffset == 0)
      |=> ##1 (outCount == CODE_W'(MID) && !outSat));

  p_sat_rail_r6: assert property (@(posedge clk) disable iff (rst)
    outSat |-> (outCount == '0 || outCount == CODE_W'(MAXC)));

  p_inner_nosat_r10: assert property (@(posedge clk) disable iff (rst)
    (outValid && outCount != '0 && outCount != CODE_W'(MAXC)) |-> !outSat);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(outCount) && $stable(outWord) && $stable(outSat)));
endmodule

bind dac_cal_corrector dcc_checker #(.CODE_W(CODE_W), .COEF_W(COEF_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inIdeal(inIdeal), .inOffset(inOffset),
  .outValid(outValid), .outCount(outCount), .outWord(outWord), .outSat(outSat)
);

// File: tb/sim_dac_cal_corrector.sv
module sim_dac_cal_corrector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [11:0] inIdeal = '0;
  logic signed [7:0] inGain = '0;
  logic signed [7:0] inOffset = '0;
  logic outValid;
  logic [11:0] outCount;
  logic [15:0] outWord;
  logic outSat;

  int total = 0;
  int bad = 0;
  logic [12:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  dac_cal_corrector u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inIdeal(inIdeal), .inGain(inGain),
    .inOffset(inOffset), .outValid(outValid), .outCount(outCount), .outWord(outWord),
    .outSat(outSat)
  );

  // model from the requirements: returns {sat, count}
  function automatic logic [12:0] model(int ideal, int g, int o);
    longint acc, mag, r;
    acc = longint'(ideal - 2048) * longint'(16384 + g) + longint'(o) * 4096 + 64'd33554432;
    mag = (acc < 0) ? -acc : acc;
    r = (mag + 8192) / 16384;
    if (acc < 0) r = -r;
    if (r < 0) return {1'b1, 12'd0};
    if (r > 4095) return {1'b1, 12'd4095};
    return {1'b0, r[11:0]};
  endfunction

  task automatic chk(string tag, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(int i, int g, int o, string tag);
    @(negedge clk);
    inValid = 1'b1;
    inIdeal = i[11:0];
    inGain = g[7:0];
    inOffset = o[7:0];
    expQ.push_back(model(i, g, o));
    tagQ.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // result monitor
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        chk("R2", 1'b0, 1, 0);
      end else begin
        logic [12:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (e[12]) t = (e[11:0] == 0) ? "R6" : "R7";
        chk(t, outCount == e[11:0], outCount, e[11:0]);
        chk(e[12] ? t : "R10", outSat == e[12], outSat, e[12]);
        chk("R8", outWord == {e[11:0], 4'h0}, outWord, {e[11:0], 4'h0});
      end
    end
  end

  initial begin
    #500us;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    logic [11:0] held;
    seed = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    chk("R1", outValid == 0 && outCount == 0 && outWord == 0 && outSat == 0, outCount, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", outValid == 0 && outCount == 0 && outWord == 0 && outSat == 0, outCount, 0);

    // latency of a lone sample (R2) with the worked example (R3, R8: 1544 -> 6080h)
    put(1536, -15, 32, "R3");
    @(negedge clk);
    inValid = 1'b0;
    chk("R2", outValid == 0, outValid, 0);
    @(negedge clk);
    chk("R2", outValid == 1, outValid, 1);
    chk("R8", outWord == 16'h6080, outWord, 16'h6080);
    idle(3);

    // R9: outputs hold while idle
    held = outCount;
    idle(5);
    chk("R9", outCount == held && outValid == 0, outCount, held);

    // rounding ties and rails, back to back
    put(2048, 0, 2, "R5");      // 2048.5 -> 2049
    put(2048, 0, -2, "R5");     // 2047.5 -> 2048
    put(0, 0, -2, "R5");        // -0.5 -> -1 -> clamp, sat
    put(0, 0, -1, "R5");        // -0.25 -> 0, no sat
    put(4095, 0, 2, "R5");      // 4095.5 -> 4096 -> clamp, sat
    put(4095, 0, 1, "R5");      // 4095.25 -> 4095, no sat
    put(4095, 127, 127, "R7");
    put(0, 127, -128, "R6");
    put(3000, -128, -128, "R4");
    put(1000, 127, 127, "R4");
    put(2048, -77, 0, "R3");
    idle(4);

    // random samples with random gaps
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 4 == 0) idle(1);
      put($urandom % 4096, int'($signed(8'($urandom))), int'($signed(8'($urandom))), "R3");
    end
    idle(5);
    chk("R2", expQ.size() == 0, expQ.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule